// File: doc/BRIEF.md
# Programmable Two-Digit Divide-by-N Counter

This block divides its clock by a programmable ratio N. It is a synchronous down-counter built from two 4-bit digit stages. The low stage decrements on every rising edge. The high stage decrements when the low stage borrows. Each stage counts in decimal (0 to 9) or in binary (0 to 15), and the two stages choose their radix independently. N is the value on the 8-bit preset bus, read as high digit times the low digit's radix plus low digit.

With reloading enabled, the counter reloads the preset whenever it holds a count of one, so a ratio of one cannot be produced. A registered terminal pulse, one clock wide, appears once every N clocks. The top bit of the high digit is brought out directly, for use as the clock of a following stage. When `reload_en` is driven low, the preset is ignored. The counter then keeps wrapping through zero, so several such blocks can be chained into a longer divider.

Top module: `divn_counter`

## Requirements
- R1: A synchronous reset, sampled on a rising edge, loads the preset into both digits and clears `zero_det`. After that edge, `q_out` equals `preset[7]`.
- R2: While `reload_en` is high and N ≥ 2, `zero_det` is high for exactly one cycle every N clocks. The first pulse follows the N-th rising edge after the reset edge. On the edge at which the count is one, the preset is reloaded.
- R3: A digit whose mode bit is 0 counts in binary. It steps from 0 to 15 with a borrow, so with both digits binary, N = 16·`preset[7:4]` + `preset[3:0]`.
- R4: A digit whose mode bit is 1 counts in BCD. It steps from 0 to 9 with a borrow. `bcd_mode[0]` selects the mode of the low digit (`preset[3:0]`) and `bcd_mode[1]` the mode of the high digit (`preset[7:4]`), independently. N = radix_low·high + low.
- R5: `q_out` is bit 3 of the high digit. With reload enabled and `preset[7]` = 0, it stays low.
- R6: While `reload_en` is low, preset changes have no effect. The count wraps from zero to the mode maximum of each digit, and `zero_det` pulses on the edge after the count was zero, with period radix_high·radix_low.
- R7: A digit in BCD mode preset above 9 decrements in binary until it is 9 or below. The period still equals radix_low·high + low.
- R8: `zero_det` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock, the frequency being divided |
| rst | input | 1 | Synchronous reset, active high; loads the preset |
| preset | input | 8 | Division ratio; [3:0] low digit, [7:4] high digit |
| bcd_mode | input | 2 | Per-digit radix: 1 = decimal, 0 = binary; bit 0 low digit |
| reload_en | input | 1 | High: reload at count one; low: preset ignored, free wrap |
| zero_det | output | 1 | One-cycle terminal pulse |
| q_out | output | 1 | Bit 3 of the high digit |

## Verification
`zero_det` is registered. It is due one edge after the count held one (or zero when reloading is off), which is the N-th edge after the reset edge and every N edges after that. `q_out` comes straight from the count register, so it is valid right after each edge, at the value N − (k mod N) reached at edge k. The bench drives and samples on the falling edge and compares each half period against these arithmetic positions. It sweeps the modes across the whole preset range in the decimal cases and across a dense grid in the binary one, then runs free-wrap cases in which the preset changes on every cycle.

// File: rtl/divn_pkg.sv
package divn_pkg;
  localparam int DIGIT_W = 4;
  localparam int BCD_TOP = 9;

  typedef logic [DIGIT_W-1:0] digit_t;

  typedef enum logic {
    RADIX_BIN = 1'b0,
    RADIX_DEC = 1'b1
  } radix_e;

  // Largest value a digit reaches when wrapping through zero.
  function automatic digit_t digit_ceiling(input radix_e radix);
    return (radix == RADIX_DEC) ? digit_t'(BCD_TOP) : '1;
  endfunction

  // Next value of a digit that is told to decrement.
  // An oversized decimal digit simply steps down in binary.
  function automatic digit_t digit_step(input digit_t cur, input radix_e radix);
    digit_t nxt;
    if (cur == '0) nxt = digit_ceiling(radix);
    else           nxt = cur - digit_t'(1);
    return nxt;
  endfunction
endpackage

// File: rtl/divn_digit.sv
module divn_digit
  import divn_pkg::*;
(
  input  logic   clk,
  input  logic   load,
  input  digit_t load_val,
  input  logic   bcd,
  input  logic   dec_en,
  output digit_t val,
  output logic   is_zero
);
  radix_e radix;
  digit_t stepped;

  always_comb begin
    radix   = bcd ? RADIX_DEC : RADIX_BIN;
    stepped = digit_step(val, radix);
  end

  assign is_zero = (val == '0);

  always_ff @(posedge clk) begin
    if (load)        val <= load_val;
    else if (dec_en) val <= stepped;
  end
endmodule

// File: rtl/divn_term_detect.sv
module divn_term_detect
  import divn_pkg::*;
#(
  parameter int NUM_DIGITS = 2
) (
  input  digit_t                low_val,
  input  logic [NUM_DIGITS-1:0] is_zero,
  input  logic                  reload_en,
  output logic                  reload_hit,
  output logic                  term_hit
);
  logic upper_zero;
  logic at_zero;
  logic at_one;

  generate
    if (NUM_DIGITS > 1) begin : g_upper
      assign upper_zero = &is_zero[NUM_DIGITS-1:1];
    end else begin : g_single
      assign upper_zero = 1'b1;
    end
  endgenerate

  assign at_zero    = &is_zero;
  assign at_one     = upper_zero && (low_val == digit_t'(1));
  assign reload_hit = reload_en && at_one;
  assign term_hit   = reload_en ? at_one : at_zero;
endmodule

// File: rtl/divn_counter.sv
module divn_counter
  import divn_pkg::*;
#(
  parameter  int NUM_DIGITS = 2,
  localparam int CNT_W      = NUM_DIGITS * DIGIT_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CNT_W-1:0]      preset,
  input  logic [NUM_DIGITS-1:0] bcd_mode,
  input  logic                  reload_en,
  output logic                  zero_det,
  output logic                  q_out
);
  logic [CNT_W-1:0]      cnt;
  logic [NUM_DIGITS-1:0] dec_en;
  logic [NUM_DIGITS-1:0] is_zero;
  logic                  reload_hit;
  logic                  term_hit;
  logic                  load_now;

  assign load_now  = rst || reload_hit;
  assign dec_en[0] = 1'b1;

  generate
    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
      if (g > 0) begin : g_chain
        assign dec_en[g] = dec_en[g-1] && is_zero[g-1];
      end
      divn_digit u_digit (
        .clk      (clk),
        .load     (load_now),
        .load_val (preset[g*DIGIT_W +: DIGIT_W]),
        .bcd      (bcd_mode[g]),
        .dec_en   (dec_en[g]),
        .val      (cnt[g*DIGIT_W +: DIGIT_W]),
        .is_zero  (is_zero[g])
      );
    end
  endgenerate

  divn_term_detect #(.NUM_DIGITS(NUM_DIGITS)) u_term (
    .low_val    (cnt[DIGIT_W-1:0]),
    .is_zero    (is_zero),
    .reload_en  (reload_en),
    .reload_hit (reload_hit),
    .term_hit   (term_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) zero_det <= 1'b0;
    else     zero_det <= term_hit;
  end

  assign q_out = cnt[CNT_W-1];
endmodule

// File: rtl/divn_counter_chk.sv
module divn_counter_chk
  import divn_pkg::*;
#(
  parameter  int NUM_DIGITS = 2,
  localparam int CNT_W      = NUM_DIGITS * DIGIT_W
) (
  input logic                  clk,
  input logic                  rst,
  input logic [CNT_W-1:0]      preset,
  input logic [NUM_DIGITS-1:0] bcd_mode,
  input logic                  reload_en,
  input logic                  zero_det,
  input logic                  q_out,
  input logic [CNT_W-1:0]      cnt,
  input logic                  reload_hit,
  input logic                  term_hit
);
  p_reset_load_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cnt == $past(preset)) && !zero_det);

  p_reload_r2: assert property (@(posedge clk) disable iff (rst)
    reload_hit |=> cnt == $past(preset));

  p_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    term_hit |=> zero_det);

  p_one_wide_r8: assert property (@(posedge clk) disable iff (rst)
    zero_det |=> !zero_det);

  p_low_step_r7: assert property (@(posedge clk) disable iff (rst)
    (!reload_hit && cnt[DIGIT_W-1:0] != '0) |=>
      cnt[DIGIT_W-1:0] == $past(cnt[DIGIT_W-1:0]) - digit_t'(1));

  p_q_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (reload_en && !preset[CNT_W-1] && $stable(preset) && !q_out) |=> !q_out);

  generate
    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dig_chk
      p_dec_range_r4: assert property (@(posedge clk) disable iff (rst)
        (bcd_mode[g] && cnt[g*DIGIT_W +: DIGIT_W] <= digit_t'(BCD_TOP) && !reload_hit)
          |=> cnt[g*DIGIT_W +: DIGIT_W] <= digit_t'(BCD_TOP));

      p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (!reload_en && cnt == '0) |=>
          cnt[g*DIGIT_W +: DIGIT_W] == ($past(bcd_mode[g]) ? digit_t'(BCD_TOP) : '1));
    end
  endgenerate
endmodule

bind divn_counter divn_counter_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .preset     (preset),
  .bcd_mode   (bcd_mode),
  .reload_en  (reload_en),
  .zero_det   (zero_det),
  .q_out      (q_out),
  .cnt        (cnt),
  .reload_hit (reload_hit),
  .term_hit   (term_hit)
);

// File: tb/divn_counter_bench.sv
module divn_counter_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] preset = 8'd2;
  logic [1:0] bcd_mode = 2'b00;
  logic       reload_en = 1'b1;
  logic       zero_det;
  logic       q_out;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  divn_counter u_divn_counter (
    .clk       (clk),
    .rst       (rst),
    .preset    (preset),
    .bcd_mode  (bcd_mode),
    .reload_en (reload_en),
    .zero_det  (zero_det),
    .q_out     (q_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reload mode: period n = hi*radix_low + lo, pulse after edges n, 2n.
  task automatic run_divide(input logic [1:0] md, input int hi, input int lo,
                            input string req, input bit chk_q);
    int rlo = md[0] ? 10 : 16;
    int n   = hi * rlo + lo;
    logic [7:0] p = {hi[3:0], lo[3:0]};
    int zd_bad = 0, q_bad = 0, zd_act = 0, zd_exp = 0, q_act = 0, q_exp = 0;
    @(negedge clk);
    preset = p; bcd_mode = md; reload_en = 1'b1; rst = 1'b1;
    @(negedge clk);
    check(zero_det == 1'b0 && q_out == p[7], "R1", "reset zd/q",
          {30'd0, zero_det, q_out}, {30'd0, 1'b0, p[7]});
    rst = 1'b0;
    for (int k = 1; k <= 2 * n; k++) begin
      int v;
      int eq;
      logic ez;
      @(negedge clk);
      ez = ((k % n) == 0);
      v  = n - (k % n);
      eq = ((v / rlo) >> 3) & 1;
      if (zero_det !== ez && zd_bad == 0) begin
        zd_bad = k; zd_act = int'(zero_det); zd_exp = int'(ez);
      end
      if (chk_q && q_out !== eq[0] && q_bad == 0) begin
        q_bad = k; q_act = int'(q_out); q_exp = eq;
      end
    end
    check(zd_bad == 0, req, $sformatf("zero_det n=%0d md=%0b cyc=%0d", n, md, zd_bad),
          zd_act, zd_exp);
    if (chk_q)
      check(q_bad == 0, "R5", $sformatf("q_out n=%0d md=%0b cyc=%0d", n, md, q_bad),
            q_act, q_exp);
  endtask

  // Free-wrap mode: count after edge k is (v0-k) mod M, pulse one edge after zero.
  task automatic run_wrap(input logic [1:0] md, input int hi, input int lo);
    int rlo = md[0] ? 10 : 16;
    int rhi = md[1] ? 10 : 16;
    int m   = rlo * rhi;
    int v0  = hi * rlo + lo;
    int zd_bad = 0, q_bad = 0, zd_act = 0, zd_exp = 0, q_act = 0, q_exp = 0;
    @(negedge clk);
    preset = {hi[3:0], lo[3:0]}; bcd_mode = md; reload_en = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int k = 1; k <= v0 + 2 * m + 1; k++) begin
      int v;
      int eq;
      logic ez;
      @(negedge clk);
      ez = (k - 1 >= v0) && (((k - 1 - v0) % m) == 0);
      v  = (v0 - k + 4 * m) % m;
      eq = ((v / rlo) >> 3) & 1;
      if (zero_det !== ez && zd_bad == 0) begin
        zd_bad = k; zd_act = int'(zero_det); zd_exp = int'(ez);
      end
      if (q_out !== eq[0] && q_bad == 0) begin
        q_bad = k; q_act = int'(q_out); q_exp = eq;
      end
      preset = 8'((k * 37 + 1) & 8'hff);  // R6: must be ignored
    end
    check(zd_bad == 0, "R6", $sformatf("wrap zero_det md=%0b cyc=%0d", md, zd_bad),
          zd_act, zd_exp);
    check(q_bad == 0, "R6", $sformatf("wrap q_out md=%0b cyc=%0d", md, q_bad),
          q_act, q_exp);
  endtask

  initial begin
    int hv[5] = '{0, 1, 7, 8, 15};
    // R3: both digits binary, dense grid
    for (int i = 0; i < 5; i++)
      for (int lo = 0; lo < 16; lo++)
        if (hv[i] * 16 + lo >= 2) run_divide(2'b00, hv[i], lo, "R3", 1'b1);
    // R4: both decimal, exhaustive
    for (int hi = 0; hi < 10; hi++)
      for (int lo = 0; lo < 10; lo++)
        if (hi * 10 + lo >= 2) run_divide(2'b11, hi, lo, "R4", 1'b1);
    // R4: mixed radix, low binary / high decimal
    for (int hi = 0; hi < 10; hi++)
      for (int lo = 0; lo < 16; lo++)
        if (hi * 16 + lo >= 2) run_divide(2'b10, hi, lo, "R4", 1'b1);
    // R4: mixed radix, low decimal / high binary
    for (int hi = 0; hi < 16; hi++)
      for (int lo = 0; lo < 10; lo++)
        if (hi * 10 + lo >= 2) run_divide(2'b01, hi, lo, "R4", 1'b1);
    // R7: oversized decimal digits
    run_divide(2'b11, 1, 12, "R7", 1'b0);
    run_divide(2'b01, 0, 15, "R7", 1'b0);
    run_divide(2'b11, 12, 5, "R7", 1'b1);
    run_divide(2'b11, 15, 9, "R7", 1'b1);
    // R6: free wrap with preset ignored
    run_wrap(2'b11, 3, 7);
    run_wrap(2'b01, 9, 4);
    run_wrap(2'b00, 0, 5);
    run_wrap(2'b10, 5, 14);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R2 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule